// File: doc/BRIEF.md
# Configurable UART Frame Receiver

This block turns an asynchronous serial line into received characters. An integer divider sets the bit period in system clocks. A falling edge on the idle-high line starts a frame, and the start bit is confirmed at its midpoint. Data, the optional parity bit and the stop bits are then sampled at the middle of each bit period, least significant bit first. Every completed character is presented on `rx_data` together with a one-cycle `rx_valid` strobe and held parity-error and frame-error flags. A separate `rx_break` strobe reports a line that stays low beyond the stop bit.

The character format is chosen at run time: 5 to 8 data bits, parity off, even or odd, and 1, 1.5 or 2 stop bits. A front stage can invert the incoming level, and it can take the line from the local transmit output instead of the pin for self-test. An idle timer measured in whole character times reports when no further character follows the last one within a programmed count.

Top module: `uart_frame_rx`

## Requirements
- R1: `cfg_len` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Data is received LSB first and presented right-aligned on `rx_data`, with the unused upper bits zero.
- R2: With `cfg_par_en`=1 one parity bit follows the data. `cfg_par_odd`=0 expects even parity and 1 expects odd parity over data plus parity bit, and a mismatch sets `rx_par_err` with the character. With `cfg_par_en`=0 no parity bit is expected and `rx_par_err` is 0.
- R3: `cfg_stop` codes 1, 2 and 3 select 1, 1.5 and 2 stop bits, and code 0 acts as 1. The first stop bit is sampled at its middle. For 1.5 stop bits a second check falls 3/4 bit period later, and for 2 stop bits one bit period later. A low level at any stop check sets `rx_frm_err` with the character.
- R4: If the first stop bit is sampled low and the line is still low one bit period later, `rx_break` pulses for one cycle. The character is still delivered, with `rx_frm_err`=1. The receiver then waits for the line to go high before it accepts a new start bit.
- R5: A low level that has ended by the midpoint of the start bit is ignored and delivers no character.
- R6: The bit period is `cfg_div` clock cycles, with `cfg_div` at least 4 and odd values allowed.
- R7: With `cfg_inv`=1 the selected input level is inverted before it is decoded.
- R8: With `cfg_loop`=1 the receiver decodes `tx_line` and ignores `rxd_pin`.
- R9: With `cfg_tout_en`=1 and `cfg_tout_thr`=T>0, `rx_tout` pulses once, T×C×`cfg_div` cycles after the end of the last `rx_valid` pulse, if the receiver stays idle that long. C = 1 + data bits + parity bit + stop bits, with 1.5 stop bits counted as 2. T=0 or `cfg_tout_en`=0 gives no pulse.
- R10: After reset `rx_valid`, `rx_break` and `rx_tout` are 0 and `rx_data` is 0.
- R11: `rx_valid` is a single-cycle pulse. `rx_data` and both error flags hold their values until the next character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd_pin | input | 1 | Serial input pin, idle high |
| tx_line | input | 1 | Local transmit line, the input source in loopback |
| cfg_div | input | 20 | Bit period in clock cycles |
| cfg_len | input | 2 | Data length code |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop | input | 2 | Stop length code |
| cfg_inv | input | 1 | Invert the input level |
| cfg_loop | input | 1 | Decode tx_line instead of rxd_pin |
| cfg_tout_en | input | 1 | Enable the idle timeout |
| cfg_tout_thr | input | 7 | Idle timeout in character times |
| rx_data | output | 8 | Last received character, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for a new character |
| rx_par_err | output | 1 | Parity mismatch on the last character |
| rx_frm_err | output | 1 | Stop check low on the last character |
| rx_break | output | 1 | One-cycle strobe for a break condition |
| rx_tout | output | 1 | One-cycle idle timeout strobe |

## Verification
The bench covers the short lengths, where a receiver that counts the wrong number of bits would shift the parity or stop bit into the data or leave stale upper bits. It targets the second stop check of the 1.5 and 2 stop formats, which a design that checks only the first stop bit would pass without a frame error. It also drives a line held low past the stop bit, where a missing break strobe, or a stuck receiver that rearms on the low level and delivers phantom characters, shows up against the queue of expected characters. Three more cases are covered. A short start glitch must not produce a character. An odd divider shows mid-bit sampling drift. The timeout is measured to the exact cycle, so an off-by-one character length or timer restart changes the measured delay.

// File: rtl/uart_rx_pkg.sv
// Shared types and helpers for the UART frame receiver.
// Assumes data lengths of 5..8 bits encoded on a 2-bit code.
package uart_rx_pkg;

    typedef enum logic [2:0] {
        RXS_IDLE,   // waiting for a falling edge
        RXS_START,  // confirming the start bit at mid-period
        RXS_DATA,   // shifting in data bits
        RXS_PAR,    // sampling the parity bit
        RXS_STOP,   // sampling the first stop bit
        RXS_STOP2,  // extra stop check for 1.5 / 2 stop bits
        RXS_BRK,    // checking for a break after a low stop bit
        RXS_HOLD    // waiting for the line to return high
    } rx_state_e;

    // Number of data bits for a length code.
    function automatic logic [3:0] data_bits(input logic [1:0] code);
        return {2'b00, code} + 4'd5;
    endfunction

    // Stop bits counted for character time (1.5 rounds up to 2).
    function automatic logic [3:0] stop_bits(input logic [1:0] code);
        return code[1] ? 4'd2 : 4'd1;
    endfunction

endpackage

// File: rtl/uart_rx_input.sv
// Input stage: selects the pin or the local transmit line, applies the
// optional inversion and synchronises the result into the clock domain.
// Assumes the inputs are asynchronous; the output resets to idle (high).
module uart_rx_input #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd_pin,
    input  logic tx_line,
    input  logic cfg_inv,
    input  logic cfg_loop,
    output logic line_o
);
    logic raw_lvl;
    logic [SYNC_STAGES-1:0] sync_q;

    // Source selection followed by level inversion.
    always_comb raw_lvl = (cfg_loop ? tx_line : rxd_pin) ^ cfg_inv;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            // Single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= raw_lvl;
            end
        end else begin : g_chain
            // Shift the level through the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_lvl};
            end
        end
    endgenerate

    assign line_o = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
// Frame decoder: confirms the start bit, samples data, parity and stop bits
// at mid-period and reports the character with its error flags and breaks.
// Assumes a synchronised idle-high line and cfg_div >= 4.
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int DIV_W  = 20,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_i,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic [1:0]        cfg_stop,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              par_err_o,
    output logic              frm_err_o,
    output logic              break_o,
    output logic              busy_o
);
    localparam int IDX_W = $clog2(DATA_W);

    rx_state_e          st;
    logic [DIV_W-1:0]   cnt;
    logic [IDX_W-1:0]   idx;
    logic [DATA_W-1:0]  shreg;
    logic               pbit;
    logic [DIV_W-1:0]   half_pt, last_pt, stop2_pt;
    logic [3:0]         nbits;
    logic               par_exp;

    // Sample points within a bit period and per-format values.
    always_comb begin
        half_pt  = cfg_div >> 1;
        last_pt  = cfg_div - 1'b1;
        stop2_pt = (cfg_stop == 2'd3) ? last_pt
                                      : (cfg_div >> 1) + (cfg_div >> 2) - 1'b1;
        nbits    = data_bits(cfg_len);
        par_exp  = cfg_par_odd ? ~^shreg : ^shreg;
    end

    // Frame state machine with the bit-period counter and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= RXS_IDLE; cnt <= '0; idx <= '0; shreg <= '0; pbit <= 1'b0;
            data_o <= '0; valid_o <= 1'b0; par_err_o <= 1'b0;
            frm_err_o <= 1'b0; break_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            break_o <= 1'b0;
            unique case (st)
                RXS_IDLE: begin
                    cnt <= '0;
                    if (!line_i) st <= RXS_START;
                end
                RXS_START: begin
                    if (cnt == half_pt) begin
                        cnt <= '0; idx <= '0; shreg <= '0; pbit <= 1'b0;
                        st  <= line_i ? RXS_IDLE : RXS_DATA;
                    end else cnt <= cnt + 1'b1;
                end
                RXS_DATA: begin
                    if (cnt == last_pt) begin
                        cnt <= '0;
                        shreg[idx] <= line_i;
                        if ({1'b0, idx} == nbits - 4'd1)
                            st <= cfg_par_en ? RXS_PAR : RXS_STOP;
                        else idx <= idx + 1'b1;
                    end else cnt <= cnt + 1'b1;
                end
                RXS_PAR: begin
                    if (cnt == last_pt) begin
                        cnt <= '0; pbit <= line_i; st <= RXS_STOP;
                    end else cnt <= cnt + 1'b1;
                end
                RXS_STOP: begin
                    if (cnt == last_pt) begin
                        cnt <= '0;
                        if (!line_i || !cfg_stop[1]) begin
                            valid_o   <= 1'b1;
                            data_o    <= shreg;
                            par_err_o <= cfg_par_en && (pbit != par_exp);
                            frm_err_o <= !line_i;
                            st        <= line_i ? RXS_IDLE : RXS_BRK;
                        end else st <= RXS_STOP2;
                    end else cnt <= cnt + 1'b1;
                end
                RXS_STOP2: begin
                    if (cnt == stop2_pt) begin
                        cnt       <= '0;
                        valid_o   <= 1'b1;
                        data_o    <= shreg;
                        par_err_o <= cfg_par_en && (pbit != par_exp);
                        frm_err_o <= !line_i;
                        st        <= line_i ? RXS_IDLE : RXS_HOLD;
                    end else cnt <= cnt + 1'b1;
                end
                RXS_BRK: begin
                    if (cnt == last_pt) begin
                        cnt <= '0;
                        break_o <= !line_i;
                        st <= RXS_HOLD;
                    end else cnt <= cnt + 1'b1;
                end
                RXS_HOLD: begin
                    if (line_i) st <= RXS_IDLE;
                end
                default: st <= RXS_IDLE;
            endcase
        end
    end

    assign busy_o = (st != RXS_IDLE);

    // R11
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    // R4
    break_has_frm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        break_o |-> frm_err_o);
    // R4
    break_not_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        break_o |-> !valid_o);
    // R2
    par_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !$past(cfg_par_en)) |-> !par_err_o);
endmodule

// File: rtl/uart_rx_idle_timer.sv
// Idle timer: after each completed character counts whole character times
// of idle receiver and pulses once when the programmed count is reached.
// Assumes char_bits >= 7 and cfg_div >= 4; a threshold of 0 never fires.
module uart_rx_idle_timer #(
    parameter int DIV_W = 20,
    parameter int THR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [THR_W-1:0] thr,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [3:0]       char_bits,
    input  logic             char_done,
    input  logic             busy,
    output logic             tout_o
);
    logic             armed;
    logic [DIV_W-1:0] cyc;
    logic [3:0]       bitc;
    logic [THR_W-1:0] chr;

    // Nested cycle / bit / character counters and the timeout strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0; cyc <= '0; bitc <= '0; chr <= '0; tout_o <= 1'b0;
        end else begin
            tout_o <= 1'b0;
            if (!en) begin
                armed <= 1'b0; cyc <= '0; bitc <= '0; chr <= '0;
            end else if (char_done) begin
                armed <= 1'b1; cyc <= '0; bitc <= '0; chr <= '0;
            end else if (!armed || busy) begin
                cyc <= '0; bitc <= '0; chr <= '0;
            end else if (cyc == cfg_div - 1'b1) begin
                cyc <= '0;
                if (bitc == char_bits - 4'd1) begin
                    bitc <= '0;
                    if ({1'b0, chr} + 1'b1 == {1'b0, thr}) begin
                        tout_o <= 1'b1; armed <= 1'b0; chr <= '0;
                    end else chr <= chr + 1'b1;
                end else bitc <= bitc + 1'b1;
            end else cyc <= cyc + 1'b1;
        end
    end

    // R9
    tout_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tout_o |=> !tout_o);
    // R9
    tout_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tout_o |-> (!$past(busy) && $past(en)));
endmodule

// File: rtl/uart_frame_rx.sv
// Top level of the configurable UART frame receiver: input selection and
// synchronisation, frame decoding, and the character-time idle timer.
// Assumes cfg_* are stable while a frame is in flight.
module uart_frame_rx
    import uart_rx_pkg::*;
#(
    parameter int DIV_W       = 20,
    parameter int THR_W       = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd_pin,
    input  logic             tx_line,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [1:0]       cfg_len,
    input  logic             cfg_par_en,
    input  logic             cfg_par_odd,
    input  logic [1:0]       cfg_stop,
    input  logic             cfg_inv,
    input  logic             cfg_loop,
    input  logic             cfg_tout_en,
    input  logic [THR_W-1:0] cfg_tout_thr,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             rx_par_err,
    output logic             rx_frm_err,
    output logic             rx_break,
    output logic             rx_tout
);
    logic       line_s;
    logic       busy;
    logic [3:0] char_bits;

    // Character length in bit periods for the idle timer.
    always_comb char_bits = 4'd1 + data_bits(cfg_len) + {3'b000, cfg_par_en}
                          + stop_bits(cfg_stop);

    uart_rx_input #(.SYNC_STAGES(SYNC_STAGES)) u_input (
        .clk(clk), .rst_n(rst_n), .rxd_pin(rxd_pin), .tx_line(tx_line),
        .cfg_inv(cfg_inv), .cfg_loop(cfg_loop), .line_o(line_s)
    );

    uart_rx_frame #(.DIV_W(DIV_W), .DATA_W(8)) u_frame (
        .clk(clk), .rst_n(rst_n), .line_i(line_s), .cfg_div(cfg_div),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop(cfg_stop), .data_o(rx_data), .valid_o(rx_valid),
        .par_err_o(rx_par_err), .frm_err_o(rx_frm_err), .break_o(rx_break),
        .busy_o(busy)
    );

    uart_rx_idle_timer #(.DIV_W(DIV_W), .THR_W(THR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .en(cfg_tout_en), .thr(cfg_tout_thr),
        .cfg_div(cfg_div), .char_bits(char_bits), .char_done(rx_valid),
        .busy(busy), .tout_o(rx_tout)
    );

    // R5
    start_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(line_s));
    // R9
    tout_not_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_tout |-> !rx_valid);
endmodule

// File: tb/tb_uart_frame_rx.sv
module tb_uart_frame_rx;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [7:0] d;
        logic       pe;
        logic       fe;
        string      req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bline = 1'b1;
    logic [19:0] cfg_div = 20'd16;
    logic [1:0]  cfg_len = 2'd3;
    logic        cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic [1:0]  cfg_stop = 2'd1;
    logic        cfg_inv = 1'b0, cfg_loop = 1'b0, cfg_tout_en = 1'b0;
    logic [6:0]  cfg_tout_thr = 7'd0;
    logic        rxd_pin, tx_line;
    logic [7:0]  rx_data;
    logic        rx_valid, rx_par_err, rx_frm_err, rx_break, rx_tout;

    int n_chk = 0, n_fail = 0;
    int cyc = 0, n_valid = 0, n_brk = 0, n_tout = 0;
    int last_valid_cyc = 0, tout_delay = -1;
    logic prev_valid = 1'b0;
    exp_t q[$];

    // In loopback the pin is held low so a leak would corrupt frames (R8).
    assign rxd_pin = cfg_loop ? 1'b0 : (bline ^ cfg_inv);
    assign tx_line = cfg_loop ? (bline ^ cfg_inv) : 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_frame_rx dut (
        .clk(clk), .rst_n(rst_n), .rxd_pin(rxd_pin), .tx_line(tx_line),
        .cfg_div(cfg_div), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_stop(cfg_stop), .cfg_inv(cfg_inv),
        .cfg_loop(cfg_loop), .cfg_tout_en(cfg_tout_en),
        .cfg_tout_thr(cfg_tout_thr), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_break(rx_break),
        .rx_tout(rx_tout)
    );

    task automatic chk(input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic hold(input logic v, input int n);
        bline = v;
        repeat (n) @(negedge clk);
    endtask

    // Driver: queue the expected character, then drive the frame.
    task automatic send(input logic [7:0] d, input bit flip, input bit bad1,
                        input bit bad2, input string req);
        int   nb, dv;
        logic [7:0] m;
        logic p;
        exp_t e;
        nb = int'(cfg_len) + 5;
        dv = int'(cfg_div);
        m  = 8'((9'd1 << nb) - 9'd1);
        e.d = d & m;
        e.pe = cfg_par_en && flip;
        e.fe = bad1 || (bad2 && cfg_stop[1]);
        e.req = req;
        q.push_back(e);
        hold(1'b0, dv);
        for (int i = 0; i < nb; i++) hold(d[i], dv);
        if (cfg_par_en) begin
            p = (^(d & m)) ^ cfg_par_odd ^ flip;
            hold(p, dv);
        end
        hold(!bad1, dv);
        if (cfg_stop == 2'd2) hold(!bad2, dv / 2);
        if (cfg_stop == 2'd3) hold(!bad2, dv);
        hold(1'b1, 2 * dv);
    endtask

    // Monitor: compare each delivered character with the queue head.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (rx_valid && prev_valid) begin
                n_chk++; n_fail++;
                $display("FAIL R11 valid pulse: actual=2 cycles expected=1");
            end
            if (rx_valid) begin
                n_valid++;
                last_valid_cyc = cyc;
                if (q.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL R5 unexpected character: actual=%0h expected=none", rx_data);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(e.req, "data", int'(rx_data), int'(e.d));
                    chk(e.req, "par_err (R2)", int'(rx_par_err), int'(e.pe));
                    chk(e.req, "frm_err (R3)", int'(rx_frm_err), int'(e.fe));
                end
            end
            if (rx_break) n_brk++;
            if (rx_tout) begin
                n_tout++;
                tout_delay = cyc - last_valid_cyc;
            end
            prev_valid = rx_valid;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int b0, v0, t0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10", "rx_valid", int'(rx_valid), 0);
        chk("R10", "rx_break", int'(rx_break), 0);
        chk("R10", "rx_tout", int'(rx_tout), 0);
        chk("R10", "rx_data", int'(rx_data), 0);
        hold(1'b1, 20);

        // R1 / R6: 8 data bits, no parity, one stop bit
        send(8'hA5, 0, 0, 0, "R1");
        send(8'h3C, 0, 0, 0, "R1");
        send(8'hFF, 0, 0, 0, "R6");
        send(8'h00, 0, 0, 0, "R6");
        // R11 data held after the strobe
        hold(1'b1, 40);
        chk("R11", "data held", int'(rx_data), 8'h00);

        // R1 shorter lengths: upper bits must be zero
        cfg_len = 2'd0; send(8'hFF, 0, 0, 0, "R1");
        cfg_len = 2'd1; send(8'hEA, 0, 0, 0, "R1");
        cfg_len = 2'd2; send(8'hD5, 0, 0, 0, "R1");
        cfg_len = 2'd3;

        // R2 parity even / odd, correct and wrong
        cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        send(8'h37, 0, 0, 0, "R2");
        send(8'h37, 1, 0, 0, "R2");
        cfg_par_odd = 1'b1;
        send(8'h81, 0, 0, 0, "R2");
        send(8'h81, 1, 0, 0, "R2");
        cfg_len = 2'd0; send(8'h15, 1, 0, 0, "R2");
        cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;

        // R3 stop lengths and frame errors
        send(8'h5A, 0, 1, 0, "R3");
        cfg_stop = 2'd2; send(8'h69, 0, 0, 0, "R3");
        send(8'h69, 0, 0, 1, "R3");
        cfg_stop = 2'd3; send(8'h96, 0, 0, 0, "R3");
        send(8'h96, 0, 0, 1, "R3");
        cfg_stop = 2'd0; send(8'h42, 0, 0, 0, "R3");
        cfg_stop = 2'd1;
        chk("R4", "no break on plain frame error", n_brk, 0);

        // R4 break: line held low beyond the stop bit
        begin
            exp_t e;
            e.d = 8'h00; e.pe = 1'b0; e.fe = 1'b1; e.req = "R4";
            q.push_back(e);
            b0 = n_brk;
            hold(1'b0, 13 * 16);
            hold(1'b1, 3 * 16);
            chk("R4", "break count", n_brk - b0, 1);
        end
        send(8'hC3, 0, 0, 0, "R4");

        // R5 short start glitch delivers nothing
        v0 = n_valid;
        hold(1'b0, 3);
        hold(1'b1, 12 * 16);
        chk("R5", "glitch ignored", n_valid - v0, 0);
        send(8'h7E, 0, 0, 0, "R5");

        // R6 odd divider
        cfg_div = 20'd11;
        send(8'hB2, 0, 0, 0, "R6");
        cfg_par_en = 1'b1; send(8'h4D, 0, 0, 0, "R6");
        cfg_par_en = 1'b0; cfg_div = 20'd16;

        // R7 inverted input
        cfg_inv = 1'b1;
        send(8'h1E, 0, 0, 0, "R7");
        send(8'hE1, 0, 0, 0, "R7");
        cfg_inv = 1'b0;

        // R8 loopback from the transmit line
        cfg_loop = 1'b1;
        send(8'h99, 0, 0, 0, "R8");
        send(8'h24, 0, 0, 0, "R8");
        cfg_loop = 1'b0;
        hold(1'b1, 20);

        // R9 idle timeout, exact delay in cycles
        chk("R9", "no timeout while disabled", n_tout, 0);
        cfg_tout_thr = 7'd2; cfg_tout_en = 1'b1;
        hold(1'b1, 4);
        t0 = n_tout;
        send(8'h11, 0, 0, 0, "R9");
        hold(1'b1, 400);
        chk("R9", "timeout count", n_tout - t0, 1);
        chk("R9", "timeout delay", tout_delay, 2 * 10 * 16 + 1);
        cfg_par_en = 1'b1; cfg_stop = 2'd3; cfg_tout_thr = 7'd1;
        t0 = n_tout;
        send(8'h22, 0, 0, 0, "R9");
        hold(1'b1, 300);
        chk("R9", "timeout count 8E2", n_tout - t0, 1);
        chk("R9", "timeout delay 8E2", tout_delay, 12 * 16 + 1);
        cfg_par_en = 1'b0; cfg_stop = 2'd1;
        cfg_tout_thr = 7'd0;
        t0 = n_tout;
        send(8'h33, 0, 0, 0, "R9");
        hold(1'b1, 400);
        chk("R9", "threshold zero never fires", n_tout - t0, 0);
        cfg_tout_en = 1'b0;

        hold(1'b1, 40);
        chk("R11", "all characters delivered", q.size(), 0);
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule